// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This controller sits between a clocked host and an external asynchronous static RAM of 16K one-bit words. The RAM has its own data-in and data-out pins. The host offers one request at a time on a valid/ready handshake. A request carries a write flag, a 14-bit word address and, for writes, one data bit. The controller turns each request into a single memory cycle. It drives the active-low chip enable, the active-low write enable, the address and the data-in line, and it samples the data-out line.

Every minimum interval of the memory is a parameter in nanoseconds. Each one is converted into a whole number of clock periods by rounding up. A read holds chip enable low with write enable high. The read bit is captured one clock after the access window has expired, and it appears on the response outputs. A write is ended by write enable, and chip enable is still low at that moment. Chip enable is released one clock later. Address and data do not change while both strobes are low.

Back-pressure rules: a request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the whole cycle time has elapsed. A request presented while `req_ready` is low waits and is not taken. The response is a single-cycle `rsp_valid` pulse and has no back-pressure. `rsp_rdata` keeps the last read bit until the next read completes.

Top module: `sram_async_ctl`

## Requirements
- R1: During and after reset, with no request, `mem_ce_n`, `mem_we_n` and `req_ready` are 1 and `rsp_valid` is 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. A request held valid while `req_ready` is 0 changes neither `mem_addr` nor the running cycle, and it is not taken in that cycle.
- R3: During a read cycle `mem_we_n` stays 1. `mem_ce_n` is 0 from the accepting edge (edge 0) until edge RD_CAP, where RD_CAP = max(ceil(T_AA/CLK), ceil(T_ACE/CLK)) + 1. With the default parameters RD_CAP is 19.
- R4: The bit on `mem_dout` is captured at edge RD_CAP of a read. It appears on `rsp_rdata`, and `rsp_valid` is 1 for exactly that one cycle. `rsp_valid` is never 1 during a write.
- R5: In a write, `mem_ce_n` falls at edge 0 and `mem_we_n` falls at edge 1. `mem_we_n` rises at edge WE_END = max(ceil(T_WP/CLK)+1, ceil(T_CW/CLK), ceil(T_AW/CLK), ceil(T_DW/CLK)). With the default parameters WE_END is 14.
- R6: `mem_addr`, and for writes `mem_din`, take the request's values at edge 0. They hold those values for the whole cycle, whatever the host drives meanwhile.
- R7: `req_ready` returns to 1 at edge RD_LEN = max(ceil(T_RC/CLK), RD_CAP) for reads, which is 19 by default. For writes it returns at edge WR_LEN = max(ceil(T_WC/CLK), WE_END+1), which is 18 by default.
- R8: While idle, both strobes stay 1, and `mem_addr` and `mem_din` hold their last values whatever appears on the request inputs.
- R9: `mem_we_n` is 0 only while `mem_ce_n` is 0. In a write, `mem_ce_n` rises at edge WE_END+1, one clock after `mem_we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller can take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle pulse: read bit available |
| rsp_rdata | output | 1 | Last bit read |
| mem_addr | output | 14 | Address to the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | 1 | Data to the RAM data-in pin |
| mem_dout | input | 1 | Data from the RAM data-out pin |

## Verification
The bench builds the controller with its defaults: a 4 ns clock and the 70 ns grade intervals. These give RD_CAP 19, RD_LEN 19, WE_END 14 and WR_LEN 18. The write end is set by the chip-enable and address windows, not by the pulse width. The read cycle is stretched by one clock beyond the cycle time by the capture edge. Because of this, a cycle that is one clock too short, or a wrong choice among the maximum terms, shows up as a wrong edge number. The bench's RAM model returns inverted data until the address access time has passed, so a capture that comes too early returns the wrong bit.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } ctl_state_e;

  // nanoseconds to whole clocks, rounded up
  function automatic int clk_count(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CAP = 19,
  parameter int RD_LEN = 19,
  parameter int WE_END = 14,
  parameter int WR_LEN = 18,
  parameter int CNT_W  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_wr,
  output logic req_ready,
  output logic accept,
  output logic ev_we_fall,
  output logic ev_we_rise,
  output logic ev_ce_rise,
  output logic ev_capture
);

  localparam logic [CNT_W-1:0] CAP_C    = CNT_W'(RD_CAP);
  localparam logic [CNT_W-1:0] RLEN_C   = CNT_W'(RD_LEN);
  localparam logic [CNT_W-1:0] WEND_C   = CNT_W'(WE_END);
  localparam logic [CNT_W-1:0] WCEUP_C  = CNT_W'(WE_END + 1);
  localparam logic [CNT_W-1:0] WLEN_C   = CNT_W'(WR_LEN);
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

  ctl_state_e       st;
  logic [CNT_W-1:0] cnt;   // equals the index of the edge being prepared
  logic             done;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign ev_capture = (st == ST_RD) && (cnt == CAP_C);
  assign ev_we_fall = (st == ST_WR) && (cnt == ONE_C);
  assign ev_we_rise = (st == ST_WR) && (cnt == WEND_C);
  assign ev_ce_rise = ev_capture || ((st == ST_WR) && (cnt == WCEUP_C));
  assign done       = ((st == ST_RD) && (cnt == RLEN_C)) ||
                      ((st == ST_WR) && (cnt == WLEN_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (st == ST_IDLE) begin
      if (req_valid) begin
        st  <= req_wr ? ST_WR : ST_RD;
        cnt <= ONE_C;
      end
    end else begin
      cnt <= cnt + ONE_C;
      if (done) st <= ST_IDLE;
    end
  end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              ev_we_fall,
  input  logic              ev_we_rise,
  input  logic              ev_ce_rise,
  input  logic              ev_capture,
  input  logic              mem_dout,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_din,
  output logic              rsp_valid,
  output logic              rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_din   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= ev_capture;
      if (ev_capture) rsp_rdata <= mem_dout;
      if (accept) begin
        mem_addr <= req_addr;
        mem_ce_n <= 1'b0;
        if (req_wr) mem_din <= req_wdata;
      end
      if (ev_we_fall) mem_we_n <= 1'b0;
      if (ev_we_rise) mem_we_n <= 1'b1;
      if (ev_ce_rise) mem_ce_n <= 1'b1;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int CLK_NS   = 4,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_ACE_NS = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 40,
  parameter int T_CW_NS  = 55,
  parameter int T_AW_NS  = 55,
  parameter int T_DW_NS  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_din,
  input  logic              mem_dout
);

  localparam int RD_CAP = imax(clk_count(T_AA_NS, CLK_NS), clk_count(T_ACE_NS, CLK_NS)) + 1;
  localparam int RD_LEN = imax(clk_count(T_RC_NS, CLK_NS), RD_CAP);
  localparam int WE_END = imax(imax(clk_count(T_WP_NS, CLK_NS) + 1, clk_count(T_CW_NS, CLK_NS)),
                               imax(clk_count(T_AW_NS, CLK_NS), clk_count(T_DW_NS, CLK_NS)));
  localparam int WR_LEN = imax(clk_count(T_WC_NS, CLK_NS), WE_END + 1);
  localparam int CNT_W  = $clog2(imax(RD_LEN, WR_LEN) + 2);

  logic accept, ev_we_fall, ev_we_rise, ev_ce_rise, ev_capture;

  sram_ctl_seq #(
    .RD_CAP(RD_CAP), .RD_LEN(RD_LEN), .WE_END(WE_END), .WR_LEN(WR_LEN), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_ready(req_ready), .accept(accept), .ev_we_fall(ev_we_fall),
    .ev_we_rise(ev_we_rise), .ev_ce_rise(ev_ce_rise), .ev_capture(ev_capture)
  );

  sram_ctl_pins #(.ADDR_W(ADDR_W)) pins_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ev_we_fall(ev_we_fall),
    .ev_we_rise(ev_we_rise), .ev_ce_rise(ev_ce_rise), .ev_capture(ev_capture),
    .mem_dout(mem_dout), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_din(mem_din), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int CLK_NS  = 4,
  parameter int T_RC_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              rsp_valid
);

  localparam int RC_CLK = clk_count(T_RC_NS, CLK_NS);
  localparam int WC_CLK = clk_count(T_WC_NS, CLK_NS);
  localparam int WP_CLK = clk_count(T_WP_NS, CLK_NS);

  logic        cur_wr;
  logic [15:0] we_low_cnt;
  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_wr     <= 1'b0;
      we_low_cnt <= '0;
      busy_cnt   <= '0;
    end else begin
      if (req_valid && req_ready) begin
        cur_wr   <= req_wr;
        busy_cnt <= '0;
      end else if (!req_ready) begin
        busy_cnt <= busy_cnt + 16'd1;
      end
      we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
    end
  end

  // R9
  we_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R9
  ce_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> ($past(mem_we_n) && mem_we_n));

  // R6
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_we_n) |=> (mem_ce_n || mem_we_n || $stable(mem_addr)));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  rd_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !cur_wr) |-> mem_we_n);

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= 16'(WP_CLK)));

  // R7
  cycle_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (busy_cnt >= (cur_wr ? 16'(WC_CLK) : 16'(RC_CLK))));

  // R4
  rsp_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cur_wr);

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_wr(req_wr), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .rsp_valid(rsp_valid)
);

// File: tb/sram_async_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctl_tb_top;

  localparam int AW  = 14;
  localparam int CLK = 4;

  function automatic int cdiv(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AA_CLK  = cdiv(70);
  localparam int EXP_CAP = mx(cdiv(70), cdiv(30)) + 1;
  localparam int EXP_RLEN = mx(cdiv(70), EXP_CAP);
  localparam int EXP_WEND = mx(mx(cdiv(40) + 1, cdiv(55)), mx(cdiv(55), cdiv(30)));
  localparam int EXP_WLEN = mx(cdiv(70), EXP_WEND + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata, mem_ce_n, mem_we_n, mem_din;
  logic [AW-1:0] mem_addr;
  logic mem_dout;

  always #2 clk = ~clk;

  sram_async_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
    .mem_dout(mem_dout)
  );

  // RAM model: bit is inverted until the address access time has passed
  bit mdl [int];
  bit exp_mem [int];
  int acc_cnt = 0;
  logic [AW-1:0] last_addr = '0;
  bit mdl_bit = 1'b0;

  always @(negedge clk) begin
    if (mem_ce_n || mem_addr != last_addr) acc_cnt <= 0;
    else acc_cnt <= acc_cnt + 1;
    last_addr <= mem_addr;
    mdl_bit <= mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 1'b0;
  end
  assign mem_dout = (!mem_ce_n && acc_cnt >= AA_CLK - 1) ? mdl_bit : ~mdl_bit;

  always @(posedge mem_we_n) begin
    if (!mem_ce_n) mdl[int'(mem_addr)] = mem_din;
  end

  int n_chk = 0, n_err = 0;
  bit fin = 1'b0;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic bit exp_bit(input logic [AW-1:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 1'b0;
  endfunction

  task automatic run_req(input bit wr, input logic [AW-1:0] a, input bit b, input bit junk);
    int n, we_fall, we_rise, ce_rise, rdv_at, rdv_n, addr_bad, din_bad, done_n;
    bit we_in_rd, rdv_val, ce_low0;
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = ~a; req_wdata = ~b; req_wr = ~wr;
    req_valid = junk;
    n = 0; we_fall = -1; we_rise = -1; ce_rise = -1; rdv_at = -1; rdv_n = 0;
    addr_bad = 0; din_bad = 0; done_n = -1; we_in_rd = 0; rdv_val = 0;
    ce_low0 = !mem_ce_n;
    forever begin
      if (mem_addr != a) addr_bad++;
      if (wr && mem_din != b) din_bad++;
      if (!mem_we_n && we_fall < 0) we_fall = n;
      if (we_fall >= 0 && mem_we_n && we_rise < 0) we_rise = n;
      if (mem_ce_n && ce_rise < 0) ce_rise = n;
      if (!wr && !mem_we_n) we_in_rd = 1;
      if (rsp_valid) begin rdv_n++; rdv_at = n; rdv_val = rsp_rdata; end
      if (req_ready) begin done_n = n; req_valid = 1'b0; break; end
      if (n > 100) break;
      @(negedge clk);
      n++;
    end
    chk("R6 addr held", addr_bad, 0);
    if (junk) chk("R2 held-off request left cycle", addr_bad + din_bad, 0);
    chk("R3/R5 ce low at accept", ce_low0, 1);
    if (wr) begin
      chk("R6 din held", din_bad, 0);
      chk("R5 we fall edge", we_fall, 1);
      chk("R5 we rise edge", we_rise, EXP_WEND);
      chk("R9 ce rise edge", ce_rise, EXP_WEND + 1);
      chk("R7 write ready edge", done_n, EXP_WLEN);
      chk("R4 no rsp in write", rdv_n, 0);
      exp_mem[int'(a)] = b;
    end else begin
      chk("R3 we high in read", we_in_rd, 0);
      chk("R3 ce rise edge", ce_rise, EXP_CAP);
      chk("R4 rsp pulse count", rdv_n, 1);
      chk("R4 rsp edge", rdv_at, EXP_CAP);
      chk("R4 read data", rdv_val, exp_bit(a));
      chk("R7 read ready edge", done_n, EXP_RLEN);
    end
    if (junk) begin
      @(negedge clk);
      chk("R2 junk not taken ce", mem_ce_n, 1);
      chk("R2 junk not taken ready", req_ready, 1);
    end
  endtask

  initial begin
    #(200000 * CLK);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int s;
    logic [AW-1:0] held;
    s = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 ce in reset", mem_ce_n, 1);
    chk("R1 we in reset", mem_we_n, 1);
    chk("R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ce after reset", mem_ce_n, 1);
    chk("R1 we after reset", mem_we_n, 1);
    chk("R1 rsp after reset", rsp_valid, 0);

    run_req(1'b1, 14'd77, 1'b1, 1'b0);
    // R8 idle: wiggle inputs with valid low
    held = mem_addr;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_addr = AW'($urandom); req_wdata = $urandom % 2;
      req_wr = $urandom % 2;
      @(negedge clk);
      chk("R8 idle ce", mem_ce_n, 1);
      chk("R8 idle we", mem_we_n, 1);
      chk("R8 idle addr", int'(mem_addr), int'(held));
      chk("R8 idle din", mem_din, 1);
    end

    // directed corners
    run_req(1'b1, 14'd0, 1'b1, 1'b0);
    run_req(1'b1, 14'd16383, 1'b1, 1'b0);
    run_req(1'b1, 14'd1, 1'b0, 1'b0);
    run_req(1'b0, 14'd0, 1'b0, 1'b0);
    run_req(1'b0, 14'd16383, 1'b0, 1'b0);
    run_req(1'b0, 14'd1, 1'b0, 1'b0);
    run_req(1'b0, 14'd5, 1'b0, 1'b0);
    run_req(1'b1, 14'd16383, 1'b0, 1'b1);
    run_req(1'b0, 14'd16383, 1'b0, 1'b1);
    run_req(1'b0, 14'd77, 1'b0, 1'b1);

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 24);
      run_req(($urandom % 2) == 1, a, ($urandom % 2) == 1, ($urandom % 5) == 0);
    end

    fin = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule